// File: doc/BRIEF.md
# DS1-to-Backplane Elastic Store with Controlled Slip

This block buffers the channel bytes of a received DS1 stream and plays them out as a 32-slot TDM backplane frame. The 24 DS1 channels map linearly onto backplane slots 0 to 23. Slots 24 to 31 carry a constant idle byte. Storage holds two backplane frames, 64 entries, arranged as two halves of 32. A write strobe stores one DS1 byte. A read strobe presents the byte for the next backplane slot. Both sides run from one clock, and each side has its own strobe.

The block measures how far the read position trails the write position, counted in channels. When the write side runs slow, this distance shrinks. When the write side runs fast, it grows. If the distance leaves the allowed window, the block moves the read position by exactly one backplane frame, so the slot sequence is unchanged. A slow writer makes the backplane repeat up to one frame of DS1 data. A fast writer makes the backplane drop up to one frame. Each slip is reported by a one-cycle pulse and a direction flag.

The lower trigger re-centres to 34 channels and the upper trigger re-centres to 10 channels. This leaves 8 channels of hysteresis on each side.

Top module: `t1eb_elastic`

## Requirements
- R1: While reset is asserted, and after it is released, `rd_byte` is 0xFF, `rd_slot` is 0, `slip_pulse` is 0 and `slip_dir` is 0. The read position starts 34 channels behind the write position, so the first read presents slot 30.
- R2: Each write strobe stores `wr_byte` at address half*32 + channel. The channel counts 0 to 23. After channel 23 the channel returns to 0 and the half toggles. A later read of that slot and half returns the stored byte.
- R3: A read strobe updates `rd_byte` and `rd_slot` at the clock edge where the strobe is sampled. Both outputs hold their values on cycles without a read strobe.
- R4: A read of slot 24 through 31 outputs the idle byte 0xFF.
- R5: The delay is (write position − read position) mod 64, taken at the read strobe before that cycle's updates. If the delay is 2 or less, the read position moves back one backplane frame, so one frame of data repeats. A slip triggered at exactly 2 leaves a delay of 34.
- R6: If the delay is 42 or more, the read position moves ahead one backplane frame, so up to one frame of data is dropped. A slip triggered at exactly 42 leaves a delay of 10.
- R7: For delays from 3 to 41 no slip occurs. A writer that keeps to one DS1 frame per backplane frame never slips.
- R8: `slip_pulse` is high for exactly the one cycle that follows a slipping read. On that cycle `slip_dir` is 1 for a repeat and 0 for a discard. `slip_dir` keeps its value until the next slip.
- R9: `rd_slot` advances by exactly one, modulo 32, on every read, including reads where a slip occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | Store `wr_byte` at the current DS1 channel |
| wr_byte | input | 8 | Received DS1 channel byte |
| rd_stb | input | 1 | Present the next backplane slot |
| rd_byte | output | 8 | Backplane byte for `rd_slot` |
| rd_slot | output | 5 | Backplane slot index of `rd_byte` |
| slip_pulse | output | 1 | One-cycle slip indication |
| slip_dir | output | 1 | Direction of the last slip: 1 repeat, 0 discard |

## Verification
The bench drives three write/read patterns and compares every result with a pointer-and-memory model built from the requirements.

The first pattern sends exactly one DS1 frame per 32 reads, with writes and reads in the same cycle. This shows that the delay stays inside the window with no slip, and that bytes land in the right slot and half. The second pattern adds one extra write per frame, so the delay climbs until a discard slip occurs. The third pattern leaves out one write per frame, so the delay falls until a repeat slip occurs.

In the second and third patterns, the first slip must have the correct direction. The bytes around that slip must repeat or skip exactly as the model predicts, and the slot numbering must stay continuous across the jump.

// File: rtl/t1eb_pkg.sv
package t1eb_pkg;

  // Direction code carried on slip_dir.
  typedef enum logic {
    SLIP_DISCARD = 1'b0,
    SLIP_REPEAT  = 1'b1
  } slip_dir_e;

endpackage

// File: rtl/t1eb_wr_ptr.sv
module t1eb_wr_ptr #(
  parameter int SLOTS  = 32,
  parameter int DS1_CH = 24,
  parameter int PTR_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  output logic [PTR_W-1:0] wr_ptr
);
  localparam int CH_W = $clog2(SLOTS);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(DS1_CH - 1);

  logic [CH_W-1:0] ch_q, ch_d;
  logic            half_q, half_d;

  // Next state: the channel runs 0..DS1_CH-1, then the half flips.
  always_comb begin
    ch_d   = ch_q;
    half_d = half_q;
    if (wr_stb) begin
      if (ch_q == LAST_CH) begin
        ch_d   = '0;
        half_d = ~half_q;
      end else begin
        ch_d = ch_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      half_q <= 1'b0;
    end else begin
      ch_q   <= ch_d;
      half_q <= half_d;
    end
  end

  assign wr_ptr = {half_q, ch_q};

endmodule

// File: rtl/t1eb_rd_ctrl.sv
module t1eb_rd_ctrl #(
  parameter int SLOTS    = 32,
  parameter int PTR_W    = 6,
  parameter int LO_TH    = 2,
  parameter int HI_TH    = 42,
  parameter int INIT_DLY = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_addr,
  output logic [PTR_W-1:0] dly,
  output logic             slip_pulse,
  output logic             slip_dir
);
  import t1eb_pkg::*;

  localparam int DEPTH = 2 * SLOTS;
  localparam logic [PTR_W-1:0] RST_PTR = PTR_W'(DEPTH - INIT_DLY);
  localparam logic [PTR_W-1:0] LO_V    = PTR_W'(LO_TH);
  localparam logic [PTR_W-1:0] HI_V    = PTR_W'(HI_TH);

  logic [PTR_W-1:0] rptr_q, rptr_d, eff;
  logic             too_close, too_far, slip;
  logic             pulse_q, pulse_d;
  slip_dir_e        dir_q, dir_d;

  // Distance and slip decision, then a one-frame jump by flipping the half bit.
  always_comb begin
    dly       = wr_ptr - rptr_q;
    too_close = (dly <= LO_V);
    too_far   = (dly >= HI_V);
    slip      = too_close | too_far;
    eff       = slip ? {~rptr_q[PTR_W-1], rptr_q[PTR_W-2:0]} : rptr_q;
    rptr_d    = rd_stb ? eff + 1'b1 : rptr_q;
    pulse_d   = rd_stb & slip;
    dir_d     = dir_q;
    if (rd_stb && slip) begin
      dir_d = too_close ? SLIP_REPEAT : SLIP_DISCARD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= RST_PTR;
      pulse_q <= 1'b0;
      dir_q   <= SLIP_DISCARD;
    end else begin
      rptr_q  <= rptr_d;
      pulse_q <= pulse_d;
      dir_q   <= dir_d;
    end
  end

  assign rd_addr    = eff;
  assign slip_pulse = pulse_q;
  assign slip_dir   = dir_q;

endmodule

// File: rtl/t1eb_store.sv
module t1eb_store #(
  parameter int                  DATA_W = 8,
  parameter int                  SLOTS  = 32,
  parameter int                  DS1_CH = 24,
  parameter int                  PTR_W  = 6,
  parameter logic [DATA_W-1:0]   IDLE   = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_stb,
  input  logic [PTR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      rd_stb,
  input  logic [PTR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [$clog2(SLOTS)-1:0]  rd_slot
);
  localparam int DEPTH  = 2 * SLOTS;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] CH_LIM = SLOT_W'(DS1_CH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] data_q, data_d;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_now;

  // Storage array: written without reset.
  always_ff @(posedge clk) begin
    if (wr_stb) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    slot_now = rd_addr[SLOT_W-1:0];
    data_d   = data_q;
    slot_d   = slot_q;
    if (rd_stb) begin
      slot_d = slot_now;
      data_d = (slot_now < CH_LIM) ? mem[rd_addr] : IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= IDLE;
      slot_q <= '0;
    end else begin
      data_q <= data_d;
      slot_q <= slot_d;
    end
  end

  assign rd_data = data_q;
  assign rd_slot = slot_q;

endmodule

// File: rtl/t1eb_elastic.sv
module t1eb_elastic #(
  parameter int                DATA_W   = 8,
  parameter int                SLOTS    = 32,
  parameter int                DS1_CH   = 24,
  parameter int                LO_TH    = 2,
  parameter int                HI_TH    = 42,
  parameter int                INIT_DLY = 34,
  parameter logic [DATA_W-1:0] IDLE     = 8'hFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [DATA_W-1:0]        wr_byte,
  input  logic                     rd_stb,
  output logic [DATA_W-1:0]        rd_byte,
  output logic [$clog2(SLOTS)-1:0] rd_slot,
  output logic                     slip_pulse,
  output logic                     slip_dir
);
  localparam int PTR_W = $clog2(2 * SLOTS);

  logic [1:0]       rst_q;
  logic             rst_n_s;
  logic [PTR_W-1:0] wr_ptr, rd_addr, dly;

  // Asynchronous assertion, two-flop synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  t1eb_wr_ptr #(.SLOTS(SLOTS), .DS1_CH(DS1_CH), .PTR_W(PTR_W)) wr_i (
    .clk(clk), .rst_n(rst_n_s), .wr_stb(wr_stb), .wr_ptr(wr_ptr)
  );

  t1eb_rd_ctrl #(.SLOTS(SLOTS), .PTR_W(PTR_W), .LO_TH(LO_TH),
                 .HI_TH(HI_TH), .INIT_DLY(INIT_DLY)) rd_i (
    .clk(clk), .rst_n(rst_n_s), .rd_stb(rd_stb), .wr_ptr(wr_ptr),
    .rd_addr(rd_addr), .dly(dly), .slip_pulse(slip_pulse), .slip_dir(slip_dir)
  );

  t1eb_store #(.DATA_W(DATA_W), .SLOTS(SLOTS), .DS1_CH(DS1_CH),
               .PTR_W(PTR_W), .IDLE(IDLE)) st_i (
    .clk(clk), .rst_n(rst_n_s), .wr_stb(wr_stb), .wr_addr(wr_ptr),
    .wr_data(wr_byte), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_byte), .rd_slot(rd_slot)
  );

endmodule

// File: rtl/t1eb_elastic_chk.sv
module t1eb_elastic_chk #(
  parameter int                DATA_W = 8,
  parameter int                SLOTS  = 32,
  parameter int                DS1_CH = 24,
  parameter int                PTR_W  = 6,
  parameter logic [DATA_W-1:0] IDLE   = 8'hFF
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_stb,
  input logic [DATA_W-1:0]        rd_byte,
  input logic [$clog2(SLOTS)-1:0] rd_slot,
  input logic                     slip_pulse,
  input logic                     slip_dir,
  input logic [PTR_W-1:0]         dly
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic have_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      have_rd <= 1'b0;
    else if (rd_stb) have_rd <= 1'b1;
  end

  // R9
  slot_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && have_rd |=> rd_slot == $past(rd_slot) + 1'b1);

  // R4
  idle_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_stb) && (rd_slot >= SLOT_W'(DS1_CH)) |-> rd_byte == IDLE);

  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |-> $past(rd_stb));

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |=> !slip_pulse);

  // R5
  repeat_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse && slip_dir |-> (dly == PTR_W'(33)) || (dly == PTR_W'(34)));

  // R6
  discard_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse && !slip_dir |-> (dly >= PTR_W'(9)) && (dly <= PTR_W'(31)));

endmodule

bind t1eb_elastic t1eb_elastic_chk #(
  .DATA_W(DATA_W), .SLOTS(SLOTS), .DS1_CH(DS1_CH), .PTR_W(PTR_W), .IDLE(IDLE)
) chk_i (
  .clk(clk), .rst_n(rst_n_s), .rd_stb(rd_stb), .rd_byte(rd_byte),
  .rd_slot(rd_slot), .slip_pulse(slip_pulse), .slip_dir(slip_dir), .dly(dly)
);

// File: tb/t1eb_elastic_tb.sv
module t1eb_elastic_tb_top;
  logic       clk;
  logic       rst_n;
  logic       wr_stb;
  logic [7:0] wr_byte;
  logic       rd_stb;
  logic [7:0] rd_byte;
  logic [4:0] rd_slot;
  logic       slip_pulse;
  logic       slip_dir;

  t1eb_elastic dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .rd_stb(rd_stb), .rd_byte(rd_byte), .rd_slot(rd_slot),
    .slip_pulse(slip_pulse), .slip_dir(slip_dir)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R2";

  // Reference model of pointers and storage.
  logic [7:0] m_mem [64];
  bit         m_val [64];
  int         m_wp, m_rp, m_seq;
  int         last_slot, last_data;
  bit         last_known;
  int         n_rep, n_dis, first_dir;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_stb = 0; wr_byte = 0; rd_stb = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk(rd_byte == 8'hFF, "R1", "rd_byte in reset", rd_byte, 255);
    chk(slip_pulse == 0, "R1", "slip_pulse in reset", slip_pulse, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 64; i++) m_val[i] = 0;
    m_wp = 0; m_rp = 30; m_seq = 1;
    last_slot = 0; last_data = 255; last_known = 1;
    n_rep = 0; n_dis = 0; first_dir = -1;
  endtask

  task automatic step(input bit w, input bit r);
    int d, a, slot, exp_d;
    bit lo, hi, known;
    logic [7:0] b;
    b = 8'(m_seq);
    wr_stb = w; wr_byte = b; rd_stb = r;
    lo = 0; hi = 0; slot = 0; exp_d = 0; known = 0;
    if (r) begin
      d  = (m_wp - m_rp) & 63;
      lo = (d <= 2);
      hi = (d >= 42);
      a  = (lo || hi) ? (m_rp ^ 32) : m_rp;
      slot = a & 31;
      if (slot >= 24) begin exp_d = 255; known = 1; end
      else begin exp_d = int'(m_mem[a]); known = m_val[a]; end
      m_rp = (a + 1) & 63;
    end
    if (w) begin
      m_mem[m_wp] = b; m_val[m_wp] = 1; m_seq++;
      m_wp = ((m_wp & 31) == 23) ? ((m_wp & 32) ^ 32) : m_wp + 1;
    end
    @(negedge clk);
    if (r) begin
      chk(rd_slot == 5'(slot), "R9", "rd_slot", rd_slot, slot);
      chk(rd_slot == 5'(last_slot + 1), "R9", "slot continuity", rd_slot, (last_slot + 1) & 31);
      if (known)
        chk(rd_byte == 8'(exp_d), (slot >= 24) ? "R4" : tag, "rd_byte", rd_byte, exp_d);
      chk(slip_pulse == (lo || hi), "R8", "slip_pulse", slip_pulse, lo || hi);
      if (lo || hi) begin
        chk(slip_dir == lo, "R8", "slip_dir", slip_dir, lo);
        if (first_dir < 0) first_dir = int'(slip_dir);
      end
      last_slot = slot; last_data = exp_d; last_known = known;
    end else begin
      chk(slip_pulse == 0, "R8", "slip_pulse without read", slip_pulse, 0);
      chk(rd_slot == 5'(last_slot), "R3", "rd_slot hold", rd_slot, last_slot);
      if (last_known)
        chk(rd_byte == 8'(last_data), "R3", "rd_byte hold", rd_byte, last_data);
    end
    if (slip_pulse) begin
      if (slip_dir) n_rep++; else n_dis++;
    end
    wr_stb = 0; rd_stb = 0;
  endtask

  // One backplane frame; extra adds a write, skip drops one.
  task automatic frame(input bit extra, input bit skip);
    for (int i = 0; i < 32; i++) begin
      step((i < 24) && !(skip && i == 5), 1'b1);
      if (extra && i == 31) step(1'b1, 1'b0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    // R1
    chk(rd_byte == 8'hFF, "R1", "rd_byte after reset", rd_byte, 255);
    chk(rd_slot == 0, "R1", "rd_slot after reset", rd_slot, 0);
    chk(slip_pulse == 0, "R1", "slip_pulse after reset", slip_pulse, 0);
    chk(slip_dir == 0, "R1", "slip_dir after reset", slip_dir, 0);
    last_slot = 29;
    step(1'b0, 1'b1);
    chk(rd_slot == 5'd30, "R1", "first read slot", rd_slot, 30);
  endtask

  task automatic t_balanced();
    do_reset(); tag = "R2"; last_slot = 29;
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    for (int f = 0; f < 5; f++) frame(1'b0, 1'b0);
    step(1'b0, 1'b0); step(1'b0, 1'b0);
    // R7
    chk(n_rep + n_dis == 0, "R7", "slips with balanced writer", n_rep + n_dis, 0);
  endtask

  task automatic t_fast();
    do_reset(); tag = "R6"; last_slot = 29;
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    for (int f = 0; f < 8; f++) frame(1'b1, 1'b0);
    // R6
    chk(n_dis > 0, "R6", "discard slips seen", n_dis, 1);
    chk(first_dir == 0, "R6", "first slip direction", first_dir, 0);
  endtask

  task automatic t_slow();
    do_reset(); tag = "R5"; last_slot = 29;
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    for (int f = 0; f < 40; f++) frame(1'b0, 1'b1);
    // R5
    chk(n_rep > 0, "R5", "repeat slips seen", n_rep, 1);
    chk(first_dir == 1, "R5", "first slip direction", first_dir, 1);
  endtask

  initial begin
    rst_n = 1'b1; wr_stb = 0; wr_byte = 0; rd_stb = 0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_balanced();
    t_fast();
    t_slow();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule